// File: doc/BRIEF.md
# Burst Data-Phase Driver with Byte-Lane Parity

This block runs the data half of a transaction on a 64-bit system bus. When the address side hands over a transfer, the block either drives write data and per-byte odd parity onto the shared data pins, or samples read data from them and checks its parity. Two bus strobes move it forward. The beat acknowledge closes a whole 64-bit beat. The sub-beat acknowledge moves to the next slice when the slave is narrower than 64 bits. A transfer is one beat, or a burst of four beats.

Write beats come in on a valid/ready stream. The producer offers a beat while `wr_ready_o` is high, and the block takes it on a cycle where `wr_valid_i` and `wr_ready_o` are both high. The block holds one beat and drives the pins from it. Read beats, and an error status when a transfer aborts, go out on a valid/ready result port. A result stays stable while `res_valid_o` is high and `res_ready_i` is low. The consumer must take a result before the next beat closes, because the bus cannot be stalled. A transfer error or a retry ends the data phase at once. An error also discards the beat that is held.

Top module: `bus_data_phase`

## Requirements
- R1: On a write, `bus_oe_o` is high in the cycle where `phase_start_i` is sampled with `is_write_i` high, and `bus_d_o` then carries beat 0, sub-beat 0.
- R2: `xfer_ack_i` closes the current beat. From the next cycle the next beat is driven, starting at sub-beat 0. A burst (`is_burst_i`=1) has 4 beats and a single transfer has 1. Without a strobe, the driven data holds.
- R3: `port_mode_i` sets the slave width W = 64 >> mode (0=64, 1=32, 2=16, 3=8 bits). Sub-beat k is the W-bit slice of the beat that starts k*W bits below the most significant bit. That slice is repeated across the whole bus. `sub_ack_i` without `xfer_ack_i` moves to sub-beat k+1 from the next cycle.
- R4: `bus_oe_o` goes low in the cycle after the final `xfer_ack_i`, after `xfer_err_i`, or after `retry_i`. It stays high until then.
- R5: Byte lane L is `bus_d_o[63-8L -: 8]` (lane 0 is the most significant byte). `bus_dp_o[L]` makes the count of ones in that lane plus its parity bit odd.
- R6: A read captures data on each cycle with `sub_ack_i` or `xfer_ack_i`. Sub-beat k of width W is taken from lanes 0..W/8-1 and placed at its R3 slice position. In the cycle after each `xfer_ack_i`, the result port holds the assembled beat with `res_err_o`=0.
- R7: On each read capture, lanes 0..W/8-1 are checked for odd parity. In the next cycle only, `perr_o` is high and `perr_mask_o[L]` is set for each failing lane L. Lanes outside the slice are ignored.
- R8: `xfer_err_i` ends the phase. The next cycle gives one result with `res_err_o`=1 and `res_data_o`=0. A held write beat is dropped.
- R9: `retry_i` (without `xfer_err_i`) ends the phase and gives no result.
- R10: While `res_valid_o` is high and `res_ready_i` is low, the result and its data hold.
- R11: `wr_ready_o` is high in idle while no beat is held, and in a write cycle with a non-final `xfer_ack_i`. It is low otherwise, including in idle with a beat held.
- R12: After reset, `bus_oe_o`, `res_valid_o` and `perr_o` are low and `wr_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_start_i | input | 1 | First cycle of the data-bus-busy period |
| is_write_i | input | 1 | Transfer direction, sampled with the start |
| is_burst_i | input | 1 | Four-beat burst, sampled with the start |
| port_mode_i | input | 2 | Slave width code, sampled with the start |
| xfer_ack_i | input | 1 | Beat acknowledge |
| sub_ack_i | input | 1 | Narrow sub-beat acknowledge |
| xfer_err_i | input | 1 | Transfer error, aborts the phase |
| retry_i | input | 1 | Retry, aborts the phase |
| wr_data_i | input | 64 | Write beat stream data |
| wr_valid_i | input | 1 | Write beat stream valid |
| wr_ready_o | output | 1 | Write beat stream ready |
| bus_d_o | output | 64 | Data driven to the pins |
| bus_dp_o | output | 8 | Parity driven to the pins |
| bus_oe_o | output | 1 | Output enable for data and parity pins |
| bus_d_i | input | 64 | Data sampled from the pins |
| bus_dp_i | input | 8 | Parity sampled from the pins |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result ready |
| res_data_o | output | 64 | Assembled read beat, zero on error |
| res_err_o | output | 1 | Result carries an error status |
| perr_o | output | 1 | Read parity error pulse |
| perr_mask_o | output | 8 | Failing lanes for the pulse |

## Verification
The assertions rely on these input rules:
- `phase_start_i` comes only while idle.
- A write starts only after its first beat is held, and a beat is on offer at every non-final write acknowledge.
- `sub_ack_i` never goes past the last slice of a beat.
- No result comes due while the previous one is still waiting.

The bench preloads each write beat before the start. It holds the next beat valid during every non-final acknowledge. It gives exactly W-slice counts of strobes per beat, and it keeps `res_ready_i` high except in one test where it stalls a single result with no further beat pending.

// File: rtl/dph_pkg.sv
`timescale 1ns/1ps
package dph_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2
  } phase_e;

  // Odd parity bit for one lane
  function automatic logic lane_odd_par(input logic [7:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/dph_seq.sv
`timescale 1ns/1ps
module dph_seq #(
  parameter int unsigned LANES     = 8,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       is_write_i,
  input  logic                       is_burst_i,
  input  logic [1:0]                 mode_i,
  input  logic                       ack_i,
  input  logic                       sub_ack_i,
  input  logic                       err_i,
  input  logic                       retry_i,
  output logic                       idle_o,
  output logic                       wr_act_o,
  output logic                       rd_act_o,
  output logic [1:0]                 mode_o,
  output logic [$clog2(LANES)-1:0]   sub_o,
  output logic                       cap_o,
  output logic                       rd_beat_done_o,
  output logic                       err_evt_o,
  output logic                       want_next_o,
  output logic                       done_o
);
  import dph_pkg::*;

  localparam int unsigned SUB_W  = $clog2(LANES);
  localparam int unsigned BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST_LEN - 1);

  phase_e            ph_q;
  logic              burst_q;
  logic [1:0]        mode_q;
  logic [BEAT_W-1:0] beat_q;
  logic [SUB_W-1:0]  sub_q;

  logic              idle, go, act, wr_e, burst_e, abort, ack_ok, sub_ok, last;
  logic [1:0]        mode_e;
  logic [BEAT_W-1:0] beat_e;
  logic [SUB_W-1:0]  sub_e;

  always_comb begin
    idle    = (ph_q == PH_IDLE);
    go      = idle && start_i;
    act     = go || !idle;
    wr_e    = idle ? is_write_i : (ph_q == PH_WR);
    burst_e = idle ? is_burst_i : burst_q;
    mode_e  = idle ? mode_i     : mode_q;
    beat_e  = idle ? '0 : beat_q;
    sub_e   = idle ? '0 : sub_q;
    abort   = act && (err_i || retry_i);
    ack_ok  = act && ack_i && !abort;
    sub_ok  = act && sub_ack_i && !ack_i && !abort;
    last    = burst_e ? (beat_e == BEAT_LAST) : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      burst_q <= 1'b0;
      mode_q  <= '0;
      beat_q  <= '0;
      sub_q   <= '0;
    end else if (abort || (ack_ok && last)) begin
      ph_q   <= PH_IDLE;
      beat_q <= '0;
      sub_q  <= '0;
    end else if (act) begin
      if (go) begin
        ph_q    <= is_write_i ? PH_WR : PH_RD;
        burst_q <= is_burst_i;
        mode_q  <= mode_i;
      end
      if (ack_ok) begin
        beat_q <= beat_e + 1'b1;
        sub_q  <= '0;
      end else if (sub_ok) begin
        sub_q <= sub_e + 1'b1;
      end
    end
  end

  assign idle_o         = idle;
  assign wr_act_o       = act && wr_e;
  assign rd_act_o       = act && !wr_e;
  assign mode_o         = mode_e;
  assign sub_o          = sub_e;
  assign cap_o          = act && !wr_e && (ack_ok || sub_ok);
  assign rd_beat_done_o = act && !wr_e && ack_ok;
  assign err_evt_o      = act && err_i;
  assign want_next_o    = act && wr_e && ack_ok && !last;
  assign done_o         = abort || (ack_ok && last);

  // Input rule: a start only while idle (R1)
  assert_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (ph_q == PH_IDLE));

  // Input rule: sub-beat strobes never pass the last slice (R3)
  assert_sub_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act && sub_ack_i && !ack_i) |-> (32'(sub_e) < ((32'd1 << mode_e) - 32'd1)));
endmodule

// File: rtl/dph_lane_steer.sv
`timescale 1ns/1ps
module dph_lane_steer #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0]                 beat_i,
  input  logic [1:0]                        mode_i,
  input  logic [$clog2(DATA_W/LANE_W)-1:0]  sub_i,
  output logic [DATA_W-1:0]                 bus_o,
  output logic [DATA_W/LANE_W-1:0]          par_o
);
  import dph_pkg::*;

  localparam int unsigned LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned LI = l;
    int unsigned       per;
    int unsigned       src;
    logic [LANE_W-1:0] lane_b;

    always_comb begin
      per    = LANES >> mode_i;
      src    = (32'(sub_i) * per + (LI & (per - 1))) & (LANES - 1);
      lane_b = LANE_W'(beat_i >> (LANE_W * (LANES - 1 - src)));
    end

    assign bus_o[DATA_W-1-LANE_W*l -: LANE_W] = lane_b;
    assign par_o[l] = lane_odd_par(8'(lane_b));
  end
endmodule

// File: rtl/dph_read_gather.sv
`timescale 1ns/1ps
module dph_read_gather #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cap_i,
  input  logic                              beat_done_i,
  input  logic                              clr_i,
  input  logic                              err_evt_i,
  input  logic [1:0]                        mode_i,
  input  logic [$clog2(DATA_W/LANE_W)-1:0]  sub_i,
  input  logic [DATA_W-1:0]                 bus_i,
  input  logic [DATA_W/LANE_W-1:0]          par_i,
  input  logic                              res_ready_i,
  output logic                              res_valid_o,
  output logic [DATA_W-1:0]                 res_data_o,
  output logic                              res_err_o,
  output logic                              perr_o,
  output logic [DATA_W/LANE_W-1:0]          perr_mask_o
);
  import dph_pkg::*;

  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] asm_q, asm_nx;
  logic [LANES-1:0]  lane_bad;

  for (genvar b = 0; b < LANES; b++) begin : g_byte
    localparam int unsigned BI = b;
    int unsigned       per;
    int unsigned       base;
    logic              hit;
    logic [LANE_W-1:0] src_b;
    logic [LANE_W-1:0] own_b;

    always_comb begin
      per   = LANES >> mode_i;
      base  = 32'(sub_i) * per;
      hit   = cap_i && (BI >= base) && (BI < base + per);
      src_b = LANE_W'(bus_i >> (LANE_W * (LANES - 1 - ((BI - base) & (LANES - 1)))));
      own_b = bus_i[DATA_W-1-LANE_W*b -: LANE_W];
    end

    assign asm_nx[DATA_W-1-LANE_W*b -: LANE_W] = hit ? src_b : asm_q[DATA_W-1-LANE_W*b -: LANE_W];
    assign lane_bad[b] = cap_i && (BI < per) && (par_i[b] != lane_odd_par(8'(own_b)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asm_q       <= '0;
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_err_o   <= 1'b0;
      perr_o      <= 1'b0;
      perr_mask_o <= '0;
    end else begin
      asm_q       <= (beat_done_i || clr_i) ? '0 : asm_nx;
      perr_o      <= |lane_bad;
      perr_mask_o <= lane_bad;
      if (beat_done_i) begin
        res_valid_o <= 1'b1;
        res_data_o  <= asm_nx;
        res_err_o   <= 1'b0;
      end else if (err_evt_i) begin
        res_valid_o <= 1'b1;
        res_data_o  <= '0;
        res_err_o   <= 1'b1;
      end else if (res_ready_i) begin
        res_valid_o <= 1'b0;
      end
    end
  end

  // Input rule: consumer drains before the next result is due
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |-> !(beat_done_i || err_evt_i));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o) && $stable(res_err_o)));

  assert_perr_after_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    perr_o |-> $past(cap_i));
endmodule

// File: rtl/bus_data_phase.sv
`timescale 1ns/1ps
module bus_data_phase #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     phase_start_i,
  input  logic                     is_write_i,
  input  logic                     is_burst_i,
  input  logic [1:0]               port_mode_i,
  input  logic                     xfer_ack_i,
  input  logic                     sub_ack_i,
  input  logic                     xfer_err_i,
  input  logic                     retry_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     wr_valid_i,
  output logic                     wr_ready_o,
  output logic [DATA_W-1:0]        bus_d_o,
  output logic [DATA_W/LANE_W-1:0] bus_dp_o,
  output logic                     bus_oe_o,
  input  logic [DATA_W-1:0]        bus_d_i,
  input  logic [DATA_W/LANE_W-1:0] bus_dp_i,
  output logic                     res_valid_o,
  input  logic                     res_ready_i,
  output logic [DATA_W-1:0]        res_data_o,
  output logic                     res_err_o,
  output logic                     perr_o,
  output logic [DATA_W/LANE_W-1:0] perr_mask_o
);
  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned SUB_W = $clog2(LANES);

  logic             idle, wr_act, rd_act, cap, rd_beat_done, err_evt, want_next, done;
  logic [1:0]       mode_e;
  logic [SUB_W-1:0] sub_e;

  logic [DATA_W-1:0] beat_q;
  logic              beat_vld_q;

  dph_seq #(.LANES(LANES), .BURST_LEN(BURST_LEN)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .start_i(phase_start_i), .is_write_i(is_write_i), .is_burst_i(is_burst_i),
    .mode_i(port_mode_i), .ack_i(xfer_ack_i), .sub_ack_i(sub_ack_i),
    .err_i(xfer_err_i), .retry_i(retry_i),
    .idle_o(idle), .wr_act_o(wr_act), .rd_act_o(rd_act), .mode_o(mode_e),
    .sub_o(sub_e), .cap_o(cap), .rd_beat_done_o(rd_beat_done),
    .err_evt_o(err_evt), .want_next_o(want_next), .done_o(done)
  );

  // One held write beat, refilled on each non-final acknowledge
  assign wr_ready_o = (idle && !beat_vld_q) || want_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q     <= '0;
      beat_vld_q <= 1'b0;
    end else if (wr_ready_o && wr_valid_i) begin
      beat_q     <= wr_data_i;
      beat_vld_q <= 1'b1;
    end else if (want_next || (wr_act && done)) begin
      beat_vld_q <= 1'b0;
    end
  end

  dph_lane_steer #(.DATA_W(DATA_W), .LANE_W(LANE_W)) steer_i (
    .beat_i(beat_q), .mode_i(mode_e), .sub_i(sub_e),
    .bus_o(bus_d_o), .par_o(bus_dp_o)
  );

  assign bus_oe_o = wr_act;

  dph_read_gather #(.DATA_W(DATA_W), .LANE_W(LANE_W)) gather_i (
    .clk(clk), .rst_n(rst_n),
    .cap_i(cap), .beat_done_i(rd_beat_done), .clr_i(done && rd_act),
    .err_evt_i(err_evt), .mode_i(mode_e), .sub_i(sub_e),
    .bus_i(bus_d_i), .par_i(bus_dp_i), .res_ready_i(res_ready_i),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o), .res_err_o(res_err_o),
    .perr_o(perr_o), .perr_mask_o(perr_mask_o)
  );

  // Input rule: a write starts with its first beat already held
  assert_first_beat_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_start_i && is_write_i) |-> beat_vld_q);

  // Input rule: a beat is on offer at every non-final write acknowledge
  assert_next_beat_offered_R11: assert property (@(posedge clk) disable iff (!rst_n)
    want_next |-> wr_valid_i);

  assert_release_after_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_o && (xfer_err_i || retry_i)) |=> (!bus_oe_o || phase_start_i));

  assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_o && !xfer_ack_i && !sub_ack_i && !xfer_err_i && !retry_i)
      |=> (bus_oe_o && $stable(bus_d_o) && $stable(bus_dp_o)));
endmodule

// File: tb/bus_data_phase_tb.sv
`timescale 1ns/1ps
module bus_data_phase_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_start_i = 0, is_write_i = 0, is_burst_i = 0;
  logic [1:0]  port_mode_i = 0;
  logic        xfer_ack_i = 0, sub_ack_i = 0, xfer_err_i = 0, retry_i = 0;
  logic [63:0] wr_data_i = 0;
  logic        wr_valid_i = 0;
  logic        wr_ready_o;
  logic [63:0] bus_d_o;
  logic [7:0]  bus_dp_o;
  logic        bus_oe_o;
  logic [63:0] bus_d_i = 0;
  logic [7:0]  bus_dp_i = 0;
  logic        res_valid_o;
  logic        res_ready_i = 1'b1;
  logic [63:0] res_data_o;
  logic        res_err_o;
  logic        perr_o;
  logic [7:0]  perr_mask_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bus_data_phase dut_i (
    .clk(clk), .rst_n(rst_n), .phase_start_i(phase_start_i), .is_write_i(is_write_i),
    .is_burst_i(is_burst_i), .port_mode_i(port_mode_i), .xfer_ack_i(xfer_ack_i),
    .sub_ack_i(sub_ack_i), .xfer_err_i(xfer_err_i), .retry_i(retry_i),
    .wr_data_i(wr_data_i), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .bus_d_o(bus_d_o), .bus_dp_o(bus_dp_o), .bus_oe_o(bus_oe_o),
    .bus_d_i(bus_d_i), .bus_dp_i(bus_dp_i), .res_valid_o(res_valid_o),
    .res_ready_i(res_ready_i), .res_data_o(res_data_o), .res_err_o(res_err_o),
    .perr_o(perr_o), .perr_mask_o(perr_mask_o)
  );

  // {write, burst, mode[1:0], seed[63:0]}
  localparam int NV = 9;
  localparam logic [67:0] VECS [NV] = '{
    {1'b1, 1'b0, 2'd0, 64'h0123_4567_89AB_CDEF},
    {1'b1, 1'b1, 2'd0, 64'hF0E1_D2C3_B4A5_9687},
    {1'b1, 1'b0, 2'd1, 64'hDEAD_BEEF_0BAD_F00D},
    {1'b1, 1'b1, 2'd3, 64'h1122_3344_5566_7788},
    {1'b1, 1'b1, 2'd2, 64'h8001_4002_2004_1008},
    {1'b0, 1'b0, 2'd0, 64'hCAFE_BABE_1357_9BDF},
    {1'b0, 1'b1, 2'd2, 64'h0F1E_2D3C_4B5A_6978},
    {1'b0, 1'b0, 2'd3, 64'hA5A5_5A5A_FF00_00FF},
    {1'b0, 1'b1, 2'd0, 64'h7766_5544_3322_1100}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] beat_of(input logic [63:0] seed, input int b);
    return seed ^ {8{8'(b * 37 + 1)}};
  endfunction

  function automatic logic [63:0] slice_of(input logic [63:0] beat, input int w, input int k);
    logic [63:0] c;
    c = beat >> (64 - (k + 1) * w);
    if (w < 64) c = c & ((64'd1 << w) - 64'd1);
    return c;
  endfunction

  function automatic logic [63:0] steer_ref(input logic [63:0] beat, input int w, input int k);
    logic [63:0] o;
    o = '0;
    for (int r = 0; r < 64 / w; r++) o = o | (slice_of(beat, w, k) << (r * w));
    return o;
  endfunction

  function automatic logic [7:0] par_ref(input logic [63:0] d);
    logic [7:0] p;
    for (int l = 0; l < 8; l++) p[l] = ~^d[63 - 8 * l -: 8];
    return p;
  endfunction

  function automatic logic [7:0] en_lanes(input int w);
    return (w == 64) ? 8'hFF : 8'((1 << (w / 8)) - 1);
  endfunction

  task automatic preload(input logic [63:0] d);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_data_i = d;
    #1 chk("R11 ready while empty", 64'(wr_ready_o), 64'd1);
    @(posedge clk); #1;
    wr_valid_i = 1'b0;
    chk("R11 not ready while held", 64'(wr_ready_o), 64'd0);
  endtask

  task automatic run_vec(input logic wr, input logic bst, input logic [1:0] md, input logic [63:0] seed);
    int nb, ns, w;
    logic [63:0] bt, drv;
    logic [7:0] en;
    nb = bst ? 4 : 1; ns = 1 << md; w = 64 >> md; en = en_lanes(w);
    if (wr) preload(beat_of(seed, 0));
    @(negedge clk);
    phase_start_i = 1'b1; is_write_i = wr; is_burst_i = bst; port_mode_i = md;
    #1;
    if (wr) begin
      chk("R1 oe at start", 64'(bus_oe_o), 64'd1);
      chk("R1 first beat", bus_d_o, steer_ref(beat_of(seed, 0), w, 0));
      chk("R5 parity", 64'(bus_dp_o), 64'(par_ref(bus_d_o)));
    end
    @(posedge clk);
    for (int b = 0; b < nb; b++) begin
      bt = beat_of(seed, b);
      for (int k = 0; k < ns; k++) begin
        @(negedge clk);
        phase_start_i = 1'b0;
        xfer_ack_i = (k == ns - 1); sub_ack_i = (k != ns - 1);
        wr_valid_i = wr && (k == ns - 1) && (b < nb - 1);
        wr_data_i = beat_of(seed, b + 1);
        drv = (slice_of(bt, w, k) << (64 - w));
        if (w < 64) drv = drv | (64'h5A5A_5A5A_5A5A_5A5A & ((64'd1 << (64 - w)) - 64'd1));
        bus_d_i = drv; bus_dp_i = par_ref(drv) ^ ~en;
        #1;
        if (wr) begin
          chk((k == 0) ? "R2 beat driven" : "R3 slice driven", bus_d_o, steer_ref(bt, w, k));
          chk("R5 parity", 64'(bus_dp_o), 64'(par_ref(bus_d_o)));
          chk("R4 oe held", 64'(bus_oe_o), 64'd1);
        end
        @(posedge clk); #1;
        if (!wr) chk("R7 no parity error on clean lanes", 64'(perr_o), 64'd0);
        if (!wr && k == ns - 1) begin
          chk("R6 result valid", 64'(res_valid_o), 64'd1);
          chk("R6 result data", res_data_o, bt);
          chk("R6 result err", 64'(res_err_o), 64'd0);
        end
      end
    end
    @(negedge clk);
    xfer_ack_i = 0; sub_ack_i = 0; wr_valid_i = 0;
    #1 chk("R4 release after final ack", 64'(bus_oe_o), 64'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [63:0] d;
    do_reset();
    #1;
    chk("R12 oe after reset", 64'(bus_oe_o), 64'd0);
    chk("R12 res_valid after reset", 64'(res_valid_o), 64'd0);
    chk("R12 perr after reset", 64'(perr_o), 64'd0);
    chk("R12 wr_ready after reset", 64'(wr_ready_o), 64'd1);

    for (int v = 0; v < NV; v++)
      run_vec(VECS[v][67], VECS[v][66], VECS[v][65:64], VECS[v][63:0]);

    // R7: bad parity on lane 2 of a full-width read
    d = 64'h1020_3040_5060_7080;
    @(negedge clk);
    phase_start_i = 1; is_write_i = 0; is_burst_i = 0; port_mode_i = 2'd0;
    @(negedge clk);
    phase_start_i = 0; xfer_ack_i = 1; bus_d_i = d; bus_dp_i = par_ref(d) ^ 8'b0000_0100;
    @(posedge clk); #1;
    chk("R7 perr pulse", 64'(perr_o), 64'd1);
    chk("R7 lane mask", 64'(perr_mask_o), 64'h04);
    chk("R6 data despite parity", res_data_o, d);
    @(negedge clk); xfer_ack_i = 0;
    @(posedge clk); #1;
    chk("R7 perr one cycle", 64'(perr_o), 64'd0);

    // R8: transfer error in the second beat of a write burst
    preload(64'hAAAA_0000_BBBB_1111);
    @(negedge clk);
    phase_start_i = 1; is_write_i = 1; is_burst_i = 1; port_mode_i = 2'd0;
    @(negedge clk);
    phase_start_i = 0; xfer_ack_i = 1; wr_valid_i = 1; wr_data_i = 64'h2222_3333_4444_5555;
    @(negedge clk);
    xfer_ack_i = 0; wr_valid_i = 0; xfer_err_i = 1;
    #1 chk("R2 second beat before error", bus_d_o, 64'h2222_3333_4444_5555);
    @(posedge clk); #1;
    chk("R8 error result valid", 64'(res_valid_o), 64'd1);
    chk("R8 error flag", 64'(res_err_o), 64'd1);
    chk("R8 error data zero", res_data_o, 64'd0);
    chk("R8 release after error", 64'(bus_oe_o), 64'd0);
    chk("R8 beat dropped, ready again", 64'(wr_ready_o), 64'd1);
    @(negedge clk); xfer_err_i = 0;

    // R9: retry aborts a write, no result
    preload(64'h0F0F_0F0F_0F0F_0F0F);
    @(negedge clk);
    phase_start_i = 1; is_write_i = 1; is_burst_i = 0; port_mode_i = 2'd1;
    @(negedge clk);
    phase_start_i = 0; retry_i = 1;
    @(posedge clk); #1;
    chk("R9 release after retry", 64'(bus_oe_o), 64'd0);
    chk("R9 no result", 64'(res_valid_o), 64'd0);
    @(negedge clk); retry_i = 0;
    @(posedge clk); #1;
    chk("R9 still no result", 64'(res_valid_o), 64'd0);

    // R10: result held under back-pressure
    d = 64'h9988_7766_5544_3322;
    @(negedge clk);
    res_ready_i = 0;
    phase_start_i = 1; is_write_i = 0; is_burst_i = 0; port_mode_i = 2'd0;
    @(negedge clk);
    phase_start_i = 0; xfer_ack_i = 1; bus_d_i = d; bus_dp_i = par_ref(d);
    @(negedge clk); xfer_ack_i = 0;
    @(posedge clk); #1;
    chk("R10 held valid", 64'(res_valid_o), 64'd1);
    chk("R10 held data", res_data_o, d);
    @(negedge clk); res_ready_i = 1;
    @(posedge clk); #1;
    chk("R10 drained", 64'(res_valid_o), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule